// File: doc/BRIEF.md
# Warp Operand Collector Unit

This block sits between warp issue and a SIMD execution unit. An issued instruction claims one collector unit. The unit records the issuing warp, the opcode, the destination register and up to three source register IDs. Each source slot carries its own valid bit, so a two-source instruction leaves its third slot unused. The unit then asks the register file for each valid source in turn. Each response carries a full-warp operand vector, one value per lane, and the unit keeps it. Once every valid slot holds its data, the unit offers the instruction and all its operands to the execution side through a valid/ready handshake. It frees itself when that handshake completes.

The number of units is a parameter. A warp may own at most one unit at a time, which rules out write-after-read hazards between two in-flight instructions of the same warp. Read responses come back tagged with the unit index and the slot index of the request they answer. The bank structure of the register file and the execution stage lie outside this block.

Each unit runs a three-state machine:
- **FREE**: the unit holds nothing.
- **COLLECT**: the unit has been allocated and is requesting and capturing operands.
- **READY**: every valid operand has arrived and the unit is offering the instruction.

Its transitions are:
- **allocate** (FREE to COLLECT): an accepted allocation selects this unit.
- **complete** (COLLECT to READY): every valid slot is ready.
- **dispatch** (READY to FREE): the dispatch handshake completes for this unit.

Top module: `warp_opcoll`

## Requirements
- R1: After reset, `alloc_ready` is 1, `rd_req_valid` is 0 and `disp_valid` is 0.
- R2: An allocation request is refused (`alloc_ready` low) while the requesting warp owns a unit. This holds until the cycle after that unit's dispatch handshake. Two busy units never carry the same warp.
- R3: An allocation request is refused when every unit is busy. An accepted request takes the lowest-index free unit.
- R4: Within one unit, reads are requested only for valid slots, in ascending slot order, with one slot per accepted request. Slot s takes its register ID from `alloc_src_reg[s*REG_W +: REG_W]`. A request carries that register ID, the unit index on `rd_req_unit` and the slot index on `rd_req_slot`.
- R5: When several units have a read pending at a fresh arbitration, the lowest-index unit is served first.
- R6: `disp_valid` stays low until every valid slot of a unit has received its response. It rises two clock edges after the edge that captures the last response.
- R7: Dispatch presents the allocated warp, opcode, destination and slot-valid bits. Slot s of `disp_data`, at `[s*LANES*DATA_W +: LANES*DATA_W]`, equals the response data for that slot. An invalid slot reads as zero.
- R8: When several units are ready at a fresh selection, the lowest-index ready unit is dispatched first.
- R9: While `disp_valid` is high and `disp_ready` is low, `disp_valid` and all dispatch outputs hold their values.
- R10: A unit is freed on the edge where its dispatch handshake completes. The same warp may allocate it in the next cycle.
- R11: An allocation with no valid slots issues no read request and is offered for dispatch two edges after the allocating edge.
- R12: While `rd_req_valid` is high and `rd_req_ready` is low, the request valid, unit, slot and register outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | Allocation accepted this cycle |
| alloc_warp | input | WARP_W | Issuing warp ID |
| alloc_opcode | input | OPC_W | Instruction opcode |
| alloc_dst | input | REG_W | Destination register ID |
| alloc_src_valid | input | NUM_SRC | Valid bit per source slot |
| alloc_src_reg | input | NUM_SRC*REG_W | Source register IDs, slot 0 in the low bits |
| rd_req_valid | output | 1 | Register-file read request |
| rd_req_ready | input | 1 | Register file accepts the request |
| rd_req_unit | output | UNIT_W | Requesting unit index |
| rd_req_slot | output | SLOT_W | Requesting slot index |
| rd_req_reg | output | REG_W | Register ID to read |
| rd_rsp_valid | input | 1 | Read response strobe |
| rd_rsp_unit | input | UNIT_W | Unit the response belongs to |
| rd_rsp_slot | input | SLOT_W | Slot the response belongs to |
| rd_rsp_data | input | LANES*DATA_W | Full-warp operand vector |
| disp_valid | output | 1 | Instruction ready for execution |
| disp_ready | input | 1 | Execution unit accepts |
| disp_warp | output | WARP_W | Warp of the dispatched instruction |
| disp_opcode | output | OPC_W | Opcode |
| disp_dst | output | REG_W | Destination register ID |
| disp_src_valid | output | NUM_SRC | Slot valid bits |
| disp_data | output | NUM_SRC*LANES*DATA_W | Operand vectors, slot 0 in the low bits |

## Verification
The bench builds the block with three units, four warps, four lanes of 16 bits and three slots. Three units allow a state where every unit is busy while a fourth warp still asks for one, which reaches the full-refusal case. The same setting gives three ready units at once, so the lowest-index order can be seen over more than one dispatch. The narrow lanes keep every slot vector small enough to compare in one line, while the per-slot layout is the same as with wide vectors. Register requests from two units are made to overlap, so the unit priority shows up mid-sequence. Responses are returned out of order to show that they are matched by their tags.

// File: rtl/opcoll_pkg.sv
package opcoll_pkg;

    typedef enum logic [1:0] {
        UNIT_FREE    = 2'd0,
        UNIT_COLLECT = 2'd1,
        UNIT_READY   = 2'd2
    } unit_state_e;

endpackage

// File: rtl/opcoll_pick.sv
module opcoll_pick #(
    parameter int N     = 2,
    parameter int IDX_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req_i,
    input  logic             take_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    logic             hold_q;
    logic [IDX_W-1:0] hold_idx_q;
    logic [IDX_W-1:0] low_idx;

    always_comb begin
        low_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) low_idx = IDX_W'(i);
        end
    end

    always_comb begin
        if (hold_q) begin
            any_o = 1'b1;
            idx_o = hold_idx_q;
        end else begin
            any_o = |req_i;
            idx_o = low_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q     <= 1'b0;
            hold_idx_q <= '0;
        end else begin
            hold_q     <= any_o && !take_i;
            hold_idx_q <= idx_o;
        end
    end

    AST_HOLD_TARGET_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |-> req_i[hold_idx_q]); // R12

endmodule

// File: rtl/opcoll_unit.sv
module opcoll_unit
    import opcoll_pkg::*;
#(
    parameter int NUM_SRC = 3,
    parameter int SLOT_W  = 2,
    parameter int REG_W   = 6,
    parameter int WARP_W  = 3,
    parameter int OPC_W   = 8,
    parameter int VEC_W   = 1024
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alloc_en,
    input  logic [WARP_W-1:0]        alloc_warp,
    input  logic [OPC_W-1:0]         alloc_opcode,
    input  logic [REG_W-1:0]         alloc_dst,
    input  logic [NUM_SRC-1:0]       alloc_src_valid,
    input  logic [NUM_SRC*REG_W-1:0] alloc_src_reg,
    input  logic                     grant_en,
    input  logic                     rsp_en,
    input  logic [SLOT_W-1:0]        rsp_slot,
    input  logic [VEC_W-1:0]         rsp_data,
    input  logic                     disp_en,
    output logic                     busy,
    output logic                     ready_out,
    output logic [WARP_W-1:0]        warp_out,
    output logic [OPC_W-1:0]         opcode_out,
    output logic [REG_W-1:0]         dst_out,
    output logic [NUM_SRC-1:0]       src_valid_out,
    output logic [NUM_SRC*VEC_W-1:0] data_out,
    output logic                     req_pend,
    output logic [SLOT_W-1:0]        req_slot,
    output logic [REG_W-1:0]         req_reg
);

    unit_state_e        state_q, state_d;
    logic [WARP_W-1:0]  warp_q;
    logic [OPC_W-1:0]   opcode_q;
    logic [REG_W-1:0]   dst_q;
    logic [NUM_SRC-1:0] sv_q, sreq_q, srdy_q, rsp_hit;
    logic [REG_W-1:0]   sreg_q  [NUM_SRC];
    logic [VEC_W-1:0]   sdata_q [NUM_SRC];
    logic               all_ready;

    assign all_ready = &(srdy_q | ~sv_q);

    always_comb begin
        for (int s = 0; s < NUM_SRC; s++) begin
            rsp_hit[s] = rsp_en && (rsp_slot == SLOT_W'(s)) && (state_q == UNIT_COLLECT)
                         && sv_q[s] && sreq_q[s] && !srdy_q[s];
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UNIT_FREE:    if (alloc_en)  state_d = UNIT_COLLECT;
            UNIT_COLLECT: if (all_ready) state_d = UNIT_READY;
            UNIT_READY:   if (disp_en)   state_d = UNIT_FREE;
            default:                     state_d = UNIT_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= UNIT_FREE;
        else        state_q <= state_d;
    end

    // slot control bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sv_q   <= '0;
            sreq_q <= '0;
            srdy_q <= '0;
        end else if (alloc_en) begin
            sv_q   <= alloc_src_valid;
            sreq_q <= '0;
            srdy_q <= '0;
        end else begin
            for (int s = 0; s < NUM_SRC; s++) begin
                if (grant_en && req_slot == SLOT_W'(s)) sreq_q[s] <= 1'b1;
                if (rsp_hit[s])                         srdy_q[s] <= 1'b1;
            end
        end
    end

    // instruction fields and operand data
    always_ff @(posedge clk) begin
        if (alloc_en) begin
            warp_q   <= alloc_warp;
            opcode_q <= alloc_opcode;
            dst_q    <= alloc_dst;
            for (int s = 0; s < NUM_SRC; s++) begin
                sreg_q[s]  <= alloc_src_reg[s*REG_W +: REG_W];
                sdata_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < NUM_SRC; s++) begin
                if (rsp_hit[s]) sdata_q[s] <= rsp_data;
            end
        end
    end

    // outputs
    always_comb begin
        busy          = (state_q != UNIT_FREE);
        ready_out     = (state_q == UNIT_READY);
        warp_out      = warp_q;
        opcode_out    = opcode_q;
        dst_out       = dst_q;
        src_valid_out = sv_q;
        req_pend      = 1'b0;
        req_slot      = '0;
        req_reg       = '0;
        for (int s = NUM_SRC - 1; s >= 0; s--) begin
            if (state_q == UNIT_COLLECT && sv_q[s] && !sreq_q[s]) begin
                req_pend = 1'b1;
                req_slot = SLOT_W'(s);
                req_reg  = sreg_q[s];
            end
        end
        for (int s = 0; s < NUM_SRC; s++) begin
            data_out[s*VEC_W +: VEC_W] = sdata_q[s];
        end
    end

    AST_READY_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == UNIT_READY |-> (srdy_q | ~sv_q) == {NUM_SRC{1'b1}}); // R6
    AST_ALLOC_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> state_q == UNIT_FREE); // R3
    AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        grant_en |-> req_pend); // R4
    AST_RDY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(srdy_q & ~sreq_q) == 0); // R4
    AST_FREE_AFTER_DISP: assert property (@(posedge clk) disable iff (!rst_n)
        ready_out && disp_en |=> state_q == UNIT_FREE); // R10

endmodule

// File: rtl/warp_opcoll.sv
module warp_opcoll #(
    parameter int NUM_UNITS = 2,
    parameter int NUM_WARPS = 8,
    parameter int NUM_SRC   = 3,
    parameter int LANES     = 32,
    parameter int DATA_W    = 32,
    parameter int REG_W     = 6,
    parameter int OPC_W     = 8,
    localparam int WARP_W   = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
    localparam int UNIT_W   = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
    localparam int SLOT_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int VEC_W    = LANES * DATA_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alloc_valid,
    output logic                     alloc_ready,
    input  logic [WARP_W-1:0]        alloc_warp,
    input  logic [OPC_W-1:0]         alloc_opcode,
    input  logic [REG_W-1:0]         alloc_dst,
    input  logic [NUM_SRC-1:0]       alloc_src_valid,
    input  logic [NUM_SRC*REG_W-1:0] alloc_src_reg,
    output logic                     rd_req_valid,
    input  logic                     rd_req_ready,
    output logic [UNIT_W-1:0]        rd_req_unit,
    output logic [SLOT_W-1:0]        rd_req_slot,
    output logic [REG_W-1:0]         rd_req_reg,
    input  logic                     rd_rsp_valid,
    input  logic [UNIT_W-1:0]        rd_rsp_unit,
    input  logic [SLOT_W-1:0]        rd_rsp_slot,
    input  logic [VEC_W-1:0]         rd_rsp_data,
    output logic                     disp_valid,
    input  logic                     disp_ready,
    output logic [WARP_W-1:0]        disp_warp,
    output logic [OPC_W-1:0]         disp_opcode,
    output logic [REG_W-1:0]         disp_dst,
    output logic [NUM_SRC-1:0]       disp_src_valid,
    output logic [NUM_SRC*VEC_W-1:0] disp_data
);

    logic [NUM_UNITS-1:0]     u_busy, u_ready, u_pend;
    logic [WARP_W-1:0]        u_warp   [NUM_UNITS];
    logic [OPC_W-1:0]         u_opcode [NUM_UNITS];
    logic [REG_W-1:0]         u_dst    [NUM_UNITS];
    logic [NUM_SRC-1:0]       u_sv     [NUM_UNITS];
    logic [NUM_SRC*VEC_W-1:0] u_data   [NUM_UNITS];
    logic [SLOT_W-1:0]        u_rslot  [NUM_UNITS];
    logic [REG_W-1:0]         u_rreg   [NUM_UNITS];

    logic              owned, free_any, alloc_fire;
    logic [UNIT_W-1:0] free_idx, req_idx, disp_idx;

    // allocation: lowest free unit, one unit per warp
    always_comb begin
        owned    = 1'b0;
        free_any = 1'b0;
        free_idx = '0;
        for (int u = NUM_UNITS - 1; u >= 0; u--) begin
            if (!u_busy[u]) begin
                free_any = 1'b1;
                free_idx = UNIT_W'(u);
            end
            if (u_busy[u] && u_warp[u] == alloc_warp) owned = 1'b1;
        end
    end

    assign alloc_ready = free_any && !owned;
    assign alloc_fire  = alloc_valid && alloc_ready;

    opcoll_pick #(.N(NUM_UNITS), .IDX_W(UNIT_W)) i_req_pick (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (u_pend),
        .take_i (rd_req_valid && rd_req_ready),
        .any_o  (rd_req_valid),
        .idx_o  (req_idx)
    );

    opcoll_pick #(.N(NUM_UNITS), .IDX_W(UNIT_W)) i_disp_pick (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (u_ready),
        .take_i (disp_valid && disp_ready),
        .any_o  (disp_valid),
        .idx_o  (disp_idx)
    );

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        opcoll_unit #(
            .NUM_SRC (NUM_SRC),
            .SLOT_W  (SLOT_W),
            .REG_W   (REG_W),
            .WARP_W  (WARP_W),
            .OPC_W   (OPC_W),
            .VEC_W   (VEC_W)
        ) i_unit (
            .clk             (clk),
            .rst_n           (rst_n),
            .alloc_en        (alloc_fire && free_idx == UNIT_W'(u)),
            .alloc_warp      (alloc_warp),
            .alloc_opcode    (alloc_opcode),
            .alloc_dst       (alloc_dst),
            .alloc_src_valid (alloc_src_valid),
            .alloc_src_reg   (alloc_src_reg),
            .grant_en        (rd_req_valid && rd_req_ready && req_idx == UNIT_W'(u)),
            .rsp_en          (rd_rsp_valid && rd_rsp_unit == UNIT_W'(u)),
            .rsp_slot        (rd_rsp_slot),
            .rsp_data        (rd_rsp_data),
            .disp_en         (disp_valid && disp_ready && disp_idx == UNIT_W'(u)),
            .busy            (u_busy[u]),
            .ready_out       (u_ready[u]),
            .warp_out        (u_warp[u]),
            .opcode_out      (u_opcode[u]),
            .dst_out         (u_dst[u]),
            .src_valid_out   (u_sv[u]),
            .data_out        (u_data[u]),
            .req_pend        (u_pend[u]),
            .req_slot        (u_rslot[u]),
            .req_reg         (u_rreg[u])
        );

        for (genvar v = u + 1; v < NUM_UNITS; v++) begin : g_pair
            AST_ONE_PER_WARP: assert property (@(posedge clk) disable iff (!rst_n)
                u_busy[u] && u_busy[v] |-> u_warp[u] != u_warp[v]); // R2
        end
    end

    assign rd_req_unit    = req_idx;
    assign rd_req_slot    = u_rslot[req_idx];
    assign rd_req_reg     = u_rreg[req_idx];
    assign disp_warp      = u_warp[disp_idx];
    assign disp_opcode    = u_opcode[disp_idx];
    assign disp_dst       = u_dst[disp_idx];
    assign disp_src_valid = u_sv[disp_idx];
    assign disp_data      = u_data[disp_idx];

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_unit)
        && $stable(rd_req_slot) && $stable(rd_req_reg)); // R12
    AST_DISP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid && !disp_ready |=> disp_valid && $stable(disp_warp)
        && $stable(disp_opcode) && $stable(disp_data)); // R9

endmodule

// File: tb/test_warp_opcoll.sv
module test_warp_opcoll;

    localparam int NU = 3, NW = 4, NS = 3, LN = 4, DW = 16, RW = 6, OW = 6;
    localparam int WW = 2, UW = 2, SW = 2, VW = LN * DW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic alloc_valid = 1'b0, alloc_ready;
    logic [WW-1:0] alloc_warp = '0;
    logic [OW-1:0] alloc_opcode = '0;
    logic [RW-1:0] alloc_dst = '0;
    logic [NS-1:0] alloc_src_valid = '0;
    logic [NS*RW-1:0] alloc_src_reg = '0;
    logic rd_req_valid, rd_req_ready = 1'b0;
    logic [UW-1:0] rd_req_unit;
    logic [SW-1:0] rd_req_slot;
    logic [RW-1:0] rd_req_reg;
    logic rd_rsp_valid = 1'b0;
    logic [UW-1:0] rd_rsp_unit = '0;
    logic [SW-1:0] rd_rsp_slot = '0;
    logic [VW-1:0] rd_rsp_data = '0;
    logic disp_valid, disp_ready = 1'b0;
    logic [WW-1:0] disp_warp;
    logic [OW-1:0] disp_opcode;
    logic [RW-1:0] disp_dst;
    logic [NS-1:0] disp_src_valid;
    logic [NS*VW-1:0] disp_data;

    int n_cmp = 0, n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    warp_opcoll #(.NUM_UNITS(NU), .NUM_WARPS(NW), .NUM_SRC(NS), .LANES(LN),
                  .DATA_W(DW), .REG_W(RW), .OPC_W(OW)) i_warp_opcoll (.*);

    function automatic logic [VW-1:0] mkvec(input int seed);
        logic [VW-1:0] v;
        for (int k = 0; k < LN; k++) v[k*DW +: DW] = DW'(seed * 97 + k * 13 + 1);
        return v;
    endfunction

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_alloc(input logic v, input int w, input logic [2:0] sv,
                             input int r0, input int r1, input int r2);
        alloc_valid     = v;
        alloc_warp      = WW'(w);
        alloc_opcode    = OW'(w * 5 + 3);
        alloc_dst       = RW'(w + 40);
        alloc_src_valid = sv;
        alloc_src_reg   = {RW'(r2), RW'(r1), RW'(r0)};
    endtask

    task automatic set_rsp(input logic v, input int u, input int s, input int seed);
        rd_rsp_valid = v;
        rd_rsp_unit  = UW'(u);
        rd_rsp_slot  = SW'(s);
        rd_rsp_data  = mkvec(seed);
    endtask

    task automatic chk_req(input string tag, input int u, input int s, input int r);
        chk({tag, " req valid"}, rd_req_valid, 1);
        chk({tag, " req unit"}, rd_req_unit, u);
        chk({tag, " req slot"}, rd_req_slot, s);
        chk({tag, " req reg"}, rd_req_reg, r);
    endtask

    task automatic t_reset;
        @(negedge clk); #1;
        chk("R1 alloc_ready", alloc_ready, 1);
        chk("R1 rd_req_valid", rd_req_valid, 0);
        chk("R1 disp_valid", disp_valid, 0);
    endtask

    task automatic t_single;
        @(negedge clk); set_alloc(1, 0, 3'b011, 5, 9, 0); #1;
        chk("R3 first alloc accepted", alloc_ready, 1);
        @(negedge clk); set_alloc(1, 0, 3'b001, 1, 1, 1); #1;
        chk("R2 owner warp refused", alloc_ready, 0);
        chk_req("R4 first slot", 0, 0, 5);
        @(negedge clk); set_alloc(0, 0, 3'b000, 0, 0, 0); #1;
        chk_req("R12 held while stalled", 0, 0, 5);
        rd_req_ready = 1'b1;
        @(negedge clk); #1;
        chk_req("R4 second slot", 0, 1, 9);
        @(negedge clk); #1;
        chk("R4 invalid slot not requested", rd_req_valid, 0);
        set_rsp(1, 0, 1, 21);
        @(negedge clk); set_rsp(1, 0, 0, 20); #1;
        chk("R6 not ready with one slot missing", disp_valid, 0);
        @(negedge clk); set_rsp(0, 0, 0, 0); #1;
        chk("R6 not ready one edge after last rsp", disp_valid, 0);
        @(negedge clk); set_alloc(1, 0, 3'b000, 0, 0, 0); #1;
        chk("R6 ready two edges after last rsp", disp_valid, 1);
        chk("R7 warp", disp_warp, 0);
        chk("R7 opcode", disp_opcode, 3);
        chk("R7 dst", disp_dst, 40);
        chk("R7 slot valid", disp_src_valid, 3'b011);
        chk("R7 slot0 data", disp_data[0*VW +: VW], mkvec(20));
        chk("R7 slot1 data", disp_data[1*VW +: VW], mkvec(21));
        chk("R7 invalid slot zero", disp_data[2*VW +: VW], 0);
        chk("R2 owner refused while ready", alloc_ready, 0);
        @(negedge clk); #1;
        chk("R9 valid held", disp_valid, 1);
        chk("R9 opcode held", disp_opcode, 3);
        chk("R9 data held", disp_data[0*VW +: VW], mkvec(20));
        disp_ready = 1'b1; #1;
        chk("R10 still owned in handshake cycle", alloc_ready, 0);
        @(negedge clk); disp_ready = 1'b0; #1;
        chk("R10 unit freed", disp_valid, 0);
        chk("R10 same warp reallocates", alloc_ready, 1);
        @(negedge clk); set_alloc(0, 0, 3'b000, 0, 0, 0); #1;
        chk("R11 no read request", rd_req_valid, 0);
        @(negedge clk); #1;
        chk("R11 ready without reads", disp_valid, 1);
        chk("R11 no valid slots", disp_src_valid, 3'b000);
        chk("R11 still no read request", rd_req_valid, 0);
        disp_ready = 1'b1;
        @(negedge clk); disp_ready = 1'b0; #1;
        chk("R10 freed after zero-source dispatch", disp_valid, 0);
    endtask

    task automatic t_fill;
        @(negedge clk); set_alloc(1, 1, 3'b000, 0, 0, 0); #1;
        chk("R3 alloc unit0", alloc_ready, 1);
        @(negedge clk); set_alloc(1, 2, 3'b000, 0, 0, 0); #1;
        chk("R3 alloc unit1", alloc_ready, 1);
        @(negedge clk); set_alloc(1, 3, 3'b000, 0, 0, 0); #1;
        chk("R3 alloc unit2", alloc_ready, 1);
        @(negedge clk); set_alloc(1, 0, 3'b000, 0, 0, 0); #1;
        chk("R3 all busy refused", alloc_ready, 0);
        @(negedge clk); set_alloc(0, 0, 3'b000, 0, 0, 0); disp_ready = 1'b1; #1;
        chk("R8 first dispatch unit0", disp_warp, 1);
        @(negedge clk); #1;
        chk("R8 second dispatch unit1", disp_warp, 2);
        chk("R8 valid", disp_valid, 1);
        @(negedge clk); #1;
        chk("R8 third dispatch unit2", disp_warp, 3);
        @(negedge clk); disp_ready = 1'b0; #1;
        chk("R10 all drained", disp_valid, 0);
        chk("R10 alloc open", alloc_ready, 1);
    endtask

    task automatic t_cross;
        rd_req_ready = 1'b1;
        @(negedge clk); set_alloc(1, 0, 3'b011, 12, 13, 0);
        @(negedge clk); set_alloc(1, 1, 3'b001, 20, 0, 0); #1;
        chk_req("R4 unit0 slot0", 0, 0, 12);
        @(negedge clk); set_alloc(0, 0, 3'b000, 0, 0, 0); #1;
        chk_req("R5 lower unit first", 0, 1, 13);
        @(negedge clk); #1;
        chk_req("R5 then unit1", 1, 0, 20);
        @(negedge clk); #1;
        chk("R4 requests exhausted", rd_req_valid, 0);
        set_rsp(1, 1, 0, 30);
        @(negedge clk); set_rsp(1, 0, 1, 31); #1;
        chk("R6 unit1 waiting", disp_valid, 0);
        @(negedge clk); set_rsp(1, 0, 0, 32); disp_ready = 1'b1; #1;
        chk("R6 unit1 ready", disp_valid, 1);
        chk("R7 unit1 warp", disp_warp, 1);
        chk("R7 unit1 slot0", disp_data[0*VW +: VW], mkvec(30));
        @(negedge clk); set_rsp(0, 0, 0, 0); #1;
        chk("R6 unit0 waiting", disp_valid, 0);
        @(negedge clk); #1;
        chk("R6 unit0 ready", disp_valid, 1);
        chk("R7 unit0 warp", disp_warp, 0);
        chk("R7 unit0 slot0", disp_data[0*VW +: VW], mkvec(32));
        chk("R7 unit0 slot1", disp_data[1*VW +: VW], mkvec(31));
        @(negedge clk); disp_ready = 1'b0; rd_req_ready = 1'b0; #1;
        chk("R10 drained", disp_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_fill();
        t_cross();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        repeat (3000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_err++;
            $display("FAIL watchdog R1-R12 run: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end

endmodule